// File: doc/BRIEF.md
# Operand Address Generator

This unit works out the 16-bit operand address for an 8-bit processor core. When `start` is asserted it captures a mode code, the program counter and both index registers. It then walks through the byte reads that the mode needs on a single synchronous read port, which returns each byte one cycle after it is requested. The bytes it reads are instruction bytes at the program counter and pointer bytes in page zero.

When the address is ready, the unit raises `done` for one cycle and holds the address on `ea`. A mode code with no memory operand raises `err` for one cycle instead. The unit issues no reads in that case. Page-crossing penalty cycles and the fetch of the operand itself belong to the surrounding core.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `done`, `err`, `busy` and `mem_rd` are all low.
- R2: Mode code 0 (immediate) makes no read and raises `done` one cycle after `start` is sampled, with `ea` equal to the sampled `pc`.
- R3: Mode code 1 (page zero) reads one byte at `pc` and returns it as `ea` with a high byte of 0x00. `done` rises three cycles after `start`.
- R4: Mode codes 2 and 3 (page zero plus X, page zero plus Y) add X (code 2) or Y (code 3) to the fetched byte modulo 256. The high byte of `ea` stays 0x00.
- R5: Mode code 4 (full address) reads `pc` and then `pc+1` (modulo 65536). The first byte is the low byte. `done` rises four cycles after `start`.
- R6: Mode codes 5 and 6 add the zero-extended X (code 5) or Y (code 6) to the 16-bit base modulo 65536. Code 6 never uses X.
- R7: Mode code 7 (pre-indexed pointer) forms the pointer (byte + X) mod 256. It reads the low byte at that pointer and the high byte at (pointer+1) mod 256, both in page zero. `done` rises five cycles after `start`.
- R8: Mode code 8 (post-indexed pointer) reads the low byte at the fetched page-zero pointer and the high byte at (pointer+1) mod 256. It then adds Y to the 16-bit value modulo 65536.
- R9: Mode codes 9 to 15 make no read, raise `err` one cycle after `start`, and never raise `done`.
- R10: Each read returns its byte on `mem_data` in the cycle after `mem_rd`. `done` and `err` are single-cycle pulses, never high together. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation (taken only when idle) |
| mode | input | 4 | Addressing mode code |
| pc | input | 16 | Program counter pointing at the first operand byte |
| xr | input | 8 | X index register |
| yr | input | 8 | Y index register |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `ea` is valid |
| err | output | 1 | One-cycle pulse: mode has no memory operand |
| ea | output | 16 | Effective address |

## Verification
Each mode is driven with ordinary operands and with operands chosen to carry out of a byte. Page-zero sums above 0xFF and a pointer at 0xFF tell true modulo-256 wrapping apart from a carry into the high byte. A base near 0xFFFF tells 16-bit wrapping apart from truncation. Different X and Y values expose a swapped index. A pulse of `start` in the middle of an operation, carrying a different mode and `pc`, shows whether a busy unit lets itself be restarted. The read count, the read addresses and the cycle at which `done` appears are compared for every mode, so a mode that skips, repeats or reorders a read is caught.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MW = 4;

  typedef enum logic [MW-1:0] {
    AM_IMM  = 4'd0,
    AM_ZP   = 4'd1,
    AM_ZPX  = 4'd2,
    AM_ZPY  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8
  } am_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OP0, S_OP1, S_HI, S_PLO, S_PHI, S_DONE, S_ERR
  } st_e;

  // page-zero sum: carry discarded
  function automatic logic [DW-1:0] zp_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  // full-width sum with zero-extended index
  function automatic logic [AW-1:0] wide_sum(input logic [AW-1:0] base, input logic [DW-1:0] idx);
    return base + {{(AW-DW){1'b0}}, idx};
  endfunction

  function automatic logic uses_y(input am_e m);
    return (m == AM_ZPY) || (m == AM_ABSY) || (m == AM_INDY);
  endfunction
endpackage

// File: rtl/opaddr_fsm.sv
module opaddr_fsm
  import opaddr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic [MW-1:0] mode,
  output st_e  st,
  output am_e  mode_q,
  output logic accept
);
  st_e st_n;
  am_e mode_in;

  assign mode_in = am_e'(mode);
  assign accept  = (st == S_IDLE) && start;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE: if (start) begin
        if (mode == AM_IMM)       st_n = S_DONE;
        else if (mode > AM_INDY)  st_n = S_ERR;
        else                      st_n = S_OP0;
      end
      S_OP0: st_n = S_OP1;
      S_OP1: begin
        if (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY) st_n = S_DONE;
        else if (mode_q == AM_INDX || mode_q == AM_INDY)             st_n = S_PLO;
        else                                                         st_n = S_HI;
      end
      S_HI:   st_n = S_DONE;
      S_PLO:  st_n = S_PHI;
      S_PHI:  st_n = S_DONE;
      S_DONE: st_n = S_IDLE;
      S_ERR:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= AM_IMM;
    end else begin
      st <= st_n;
      if (accept) mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/opaddr_dp.sv
module opaddr_dp
  import opaddr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  st_e           st,
  input  am_e           mode_q,
  input  logic          accept,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] xr,
  input  logic [DW-1:0] yr,
  input  logic [DW-1:0] mem_data,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] ea
);
  localparam logic [AW-DW-1:0] PAGE0 = '0;

  logic [AW-1:0] pc_q, ea_q;
  logic [DW-1:0] x_q, y_q, b0_q, ptr_q, lo_q;
  logic [DW-1:0] idx_w, ptr_now;
  logic          is_abs, is_ind, is_zp;

  assign idx_w   = uses_y(mode_q) ? y_q : x_q;
  assign ptr_now = (mode_q == AM_INDX) ? zp_sum(mem_data, x_q) : mem_data;
  assign is_zp   = (mode_q == AM_ZP) || (mode_q == AM_ZPX) || (mode_q == AM_ZPY);
  assign is_ind  = (mode_q == AM_INDX) || (mode_q == AM_INDY);
  assign is_abs  = !is_zp && !is_ind;
  assign ea      = ea_q;

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    unique case (st)
      S_OP0: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q;
      end
      S_OP1: begin
        if (is_abs) begin
          mem_rd   = 1'b1;
          mem_addr = pc_q + 1'b1;
        end else if (is_ind) begin
          mem_rd   = 1'b1;
          mem_addr = {PAGE0, ptr_now};
        end
      end
      S_PLO: begin
        mem_rd   = 1'b1;
        mem_addr = {PAGE0, zp_sum(ptr_q, 8'd1)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; ea_q <= '0; x_q <= '0; y_q <= '0;
      b0_q <= '0; ptr_q <= '0; lo_q <= '0;
    end else begin
      if (accept) begin
        pc_q <= pc;
        x_q  <= xr;
        y_q  <= yr;
        if (mode == AM_IMM) ea_q <= pc;
      end
      unique case (st)
        S_OP1: begin
          b0_q  <= mem_data;
          ptr_q <= ptr_now;
          if (mode_q == AM_ZP)  ea_q <= {PAGE0, mem_data};
          else if (is_zp)       ea_q <= {PAGE0, zp_sum(mem_data, idx_w)};
        end
        S_HI:  ea_q <= (mode_q == AM_ABS) ? {mem_data, b0_q}
                                          : wide_sum({mem_data, b0_q}, idx_w);
        S_PLO: lo_q <= mem_data;
        S_PHI: ea_q <= (mode_q == AM_INDY) ? wide_sum({mem_data, lo_q}, y_q)
                                           : {mem_data, lo_q};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [15:0]   pc,
  input  logic [7:0]    xr,
  input  logic [7:0]    yr,
  output logic          mem_rd,
  output logic [15:0]   mem_addr,
  input  logic [7:0]    mem_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [15:0]   ea
);
  st_e  st_w;
  am_e  mode_q_w;
  logic accept_w;

  opaddr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .st(st_w), .mode_q(mode_q_w), .accept(accept_w)
  );

  opaddr_dp u_dp (
    .clk(clk), .rst_n(rst_n), .st(st_w), .mode_q(mode_q_w), .accept(accept_w),
    .mode(mode), .pc(pc), .xr(xr), .yr(yr), .mem_data(mem_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .ea(ea)
  );

  assign busy = (st_w != S_IDLE);
  assign done = (st_w == S_DONE);
  assign err  = (st_w == S_ERR);
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic [15:0] pc,
  input logic        mem_rd,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] ea,
  input logic [3:0]  mode_q
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  // R9
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> !mem_rd);
  // R1
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_rd);
  // R2
  imm_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd0) |=> (done && ea == $past(pc)));
  // R4
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q >= 4'd1 && mode_q <= 4'd3) |-> (ea[15:8] == 8'h00));
  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode > 4'd8) |=> err);
endmodule

bind opaddr_gen opaddr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
  .mem_rd(mem_rd), .busy(busy), .done(done), .err(err), .ea(ea),
  .mode_q(mode_q_w)
);

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  xr = '0, yr = '0;
  logic        mem_rd, busy, done, err;
  logic [15:0] mem_addr, ea;
  logic [7:0]  mem_data = '0;

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0;
  logic [15:0] rd_log [0:63];
  logic [15:0] ov_a [0:3];
  logic [7:0]  ov_d [0:3];
  logic        ov_v [0:3];

  always #4 clk = ~clk;

  opaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
    .xr(xr), .yr(yr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .done(done), .err(err), .ea(ea)
  );

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    logic [7:0] v;
    v = (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
    for (int i = 0; i < 4; i++) if (ov_v[i] && ov_a[i] == a) v = ov_d[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= byte_at(mem_addr);
      rd_log[rd_cnt[5:0]] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_pokes();
    for (int i = 0; i < 4; i++) ov_v[i] = 1'b0;
  endtask

  task automatic poke(input int i, input logic [15:0] a, input logic [7:0] d);
    ov_a[i] = a; ov_d[i] = d; ov_v[i] = 1'b1;
  endtask

  // reference model written from the requirements
  task automatic model(input logic [3:0] m, input logic [15:0] p, input logic [7:0] x,
                       input logic [7:0] y, output logic [15:0] e, output int nrd,
                       output logic [15:0] ra [0:2], output int lat, output bit bad);
    logic [7:0] b, ptr, lo, hi;
    bad = 0; nrd = 0; e = 0; lat = 1;
    for (int i = 0; i < 3; i++) ra[i] = 0;
    if (m == 0) e = p;
    else if (m > 8) bad = 1;
    else begin
      b = byte_at(p); ra[0] = p; nrd = 1;
      if (m <= 3) begin
        lat = 3;
        e = {8'h00, (m == 1) ? b : (m == 2) ? 8'(b + x) : 8'(b + y)};
      end else if (m <= 6) begin
        lat = 4; nrd = 2; ra[1] = p + 16'd1;
        hi = byte_at(ra[1]);
        e = {hi, b} + ((m == 5) ? {8'h00, x} : (m == 6) ? {8'h00, y} : 16'h0000);
      end else begin
        lat = 5; nrd = 3;
        ptr = (m == 7) ? 8'(b + x) : b;
        ra[1] = {8'h00, ptr}; ra[2] = {8'h00, 8'(ptr + 8'd1)};
        lo = byte_at(ra[1]); hi = byte_at(ra[2]);
        e = {hi, lo} + ((m == 8) ? {8'h00, y} : 16'h0000);
      end
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] m, input logic [15:0] p,
                        input logic [7:0] x, input logic [7:0] y);
    logic [15:0] e; logic [15:0] ra [0:2]; int nrd, lat, base, cyc; bit bad, hit;
    model(m, p, x, y, e, nrd, ra, lat, bad);
    @(negedge clk);
    mode = m; pc = p; xr = x; yr = y; start = 1'b1;
    base = rd_cnt;
    @(negedge clk); start = 1'b0; mode = 4'hE; pc = 16'hDEAD;
    cyc = 1; hit = 0;
    while (cyc <= 12 && !hit) begin
      if (done || err) hit = 1;
      else begin @(negedge clk); cyc++; end
    end
    chk(hit, req, "completion seen", {31'd0, hit}, 1);
    chk(cyc == lat, req, "latency", cyc, lat);
    chk(err == bad && done == !bad, req, "done/err kind", {done, err}, {!bad, bad});
    if (!bad) chk(ea == e, req, "address", ea, e);
    chk(rd_cnt - base == nrd, req, "read count", rd_cnt - base, nrd);
    for (int i = 0; i < 3; i++)
      if (i < nrd) chk(rd_log[6'(base + i)] == ra[i], req, "read address", rd_log[6'(base + i)], ra[i]);
    @(negedge clk);
    chk(!done && !err && !busy, "R10", "pulse width", {done, err, busy}, 0);
  endtask

  task automatic t_reset();
    chk(!done && !err && !busy && !mem_rd, "R1", "reset outputs", {done, err, busy, mem_rd}, 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] e; logic [15:0] ra [0:2]; int nrd, lat, cyc; bit bad;
    clear_pokes();
    model(4'd4, 16'h2200, 8'h00, 8'h00, e, nrd, ra, lat, bad);
    @(negedge clk); mode = 4'd4; pc = 16'h2200; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; mode = 4'd0; pc = 16'h7777;
    @(negedge clk); start = 1'b0; cyc = 3;
    while (cyc < 12 && !done) begin @(negedge clk); cyc++; end
    chk(done && ea == e, "R10", "start ignored while busy", ea, e);
    chk(cyc == 4, "R10", "latency unaffected", cyc, 4);
    @(negedge clk);
    chk(!busy && !done, "R10", "no restart after ignored start", {busy, done}, 0);
  endtask

  initial begin
    clear_pokes();
    #20;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    run_op("R2", 4'd0, 16'h1234, 8'h11, 8'h22);
    clear_pokes(); poke(0, 16'h0400, 8'h7E);
    run_op("R3", 4'd1, 16'h0400, 8'h05, 8'h06);
    clear_pokes(); poke(0, 16'h0410, 8'hF0);
    run_op("R4", 4'd2, 16'h0410, 8'h20, 8'h01);
    clear_pokes(); poke(0, 16'h0420, 8'hE0);
    run_op("R4", 4'd3, 16'h0420, 8'h99, 8'h35);
    clear_pokes();
    run_op("R5", 4'd4, 16'h8000, 8'h00, 8'h00);
    run_op("R5", 4'd4, 16'hFFFF, 8'h00, 8'h00);
    clear_pokes(); poke(0, 16'h9000, 8'hFF); poke(1, 16'h9001, 8'h12);
    run_op("R6", 4'd5, 16'h9000, 8'h01, 8'h40);
    run_op("R6", 4'd6, 16'h9000, 8'h11, 8'h22);
    clear_pokes(); poke(0, 16'h9100, 8'hF0); poke(1, 16'h9101, 8'hFF);
    run_op("R6", 4'd5, 16'h9100, 8'h20, 8'h00);
    run_op("R6", 4'd6, 16'h9100, 8'h00, 8'h30);
    clear_pokes(); poke(0, 16'h0500, 8'hFE); poke(1, 16'h00FF, 8'h34); poke(2, 16'h0000, 8'h12);
    run_op("R7", 4'd7, 16'h0500, 8'h01, 8'h77);
    clear_pokes();
    run_op("R7", 4'd7, 16'h0510, 8'h9C, 8'h00);
    clear_pokes(); poke(0, 16'h0600, 8'h40); poke(1, 16'h0040, 8'hF0); poke(2, 16'h0041, 8'h20);
    run_op("R8", 4'd8, 16'h0600, 8'h55, 8'h20);
    clear_pokes(); poke(0, 16'h0610, 8'hFF); poke(1, 16'h00FF, 8'hF8); poke(2, 16'h0000, 8'hFF);
    run_op("R8", 4'd8, 16'h0610, 8'h00, 8'h10);
    clear_pokes();
    run_op("R9", 4'd9, 16'h3000, 8'h00, 8'h00);
    run_op("R9", 4'd15, 16'h3000, 8'h00, 8'h00);
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule